// File: doc/BRIEF.md
# Dual-Address Paged I2C Register Target

This block is an I2C target that answers at two 7-bit device addresses: 51h and 59h, which are A2h and B2h when the read/write bit is included. Each address serves one transmitter channel. Every address shows a 128-byte lower region (00h–7Fh) that belongs to its own channel. It also shows a 128-byte upper window (80h–FFh), and the table-select byte of the addressed channel picks the table in that window. One table (02h) is backed by a single store, so it reads and writes the same through either address. A mask bit in that shared table moves the eight alarm/warning enable bytes out of table 01h and into table 05h.

The target samples SCL and SDA with the system clock through synchronisers. It only pulls SDA low, through an open-drain enable. It handles byte writes, sequential writes, current-address reads and random reads that begin with a dummy write. One address counter serves both device addresses. The counter steps after every byte and stays within the 128-byte half it is in. The storage is built from register arrays.

Top module: `i2c_paged_slave`

## Requirements
- R1: Device bytes with address 51h or 59h (A2h/B2h including the R/W bit) are acknowledged. Any other address gets a NACK, and SDA stays released until the next START.
- R2: Each device address has its own 128-byte lower region at 00h–7Fh. All storage reads 00h after reset.
- R3: The lower byte at 7Fh of the addressed device selects the upper-window table. Table 01h is per device, table 02h is shared, and table 05h is conditional (R5). Every other table reads FFh and ignores writes.
- R4: A byte written to table 02h through either device address reads back the same through both.
- R5: Bit 0 of shared table 02h offset 88h is the mask bit. When it is 1, table 01h reads FFh and ignores writes, and the per-device enable bytes F8h–FFh of table 01h appear in table 05h. When it is 0, table 05h reads FFh and ignores writes.
- R6: In a write, the first byte after the device address loads the address counter. Each following byte is stored at the counter. The target acknowledges every byte.
- R7: A random read (device write, memory address, repeated START, device read) returns data from the given address. A read with no address phase returns data from the current counter.
- R8: The counter increments after each byte read or written. It wraps from 7Fh to 00h and from FFh to 80h, so it never leaves its current half.
- R9: A master NACK ends a read. A STOP returns the target to idle, and a START always restarts the address phase.
- R10: SDA is pulled low only during an acknowledge or a read data bit. The drive changes only after an SCL falling edge, a START or a STOP, and it is released in idle and after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
A table of single-byte writes, each followed by a random read, covers the lower regions of both devices, tables 01h and 02h, and two unimplemented selections. This separates per-device storage from shared storage and decoded tables from FFh tables. Sequential writes and reads that cross FFh and 7Fh show that the counter wraps inside its half and does not spill into the other. A current-address read that follows a random read shows that the counter is kept between transfers. A foreign device address, together with the mask bit toggled both ways, shows that neither a NACKed transfer nor a masked-off write leaves any trace in the stored bytes.

// File: rtl/i2c_pg_pkg.sv
`timescale 1ns/1ps
package i2c_pg_pkg;
  localparam int BYTE_W  = 8;
  localparam int REGION  = 128;
  localparam int REG_AW  = $clog2(REGION);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } tgt_state_e;

  typedef enum logic [1:0] {
    HIT_LOW, HIT_T01, HIT_T02, HIT_NONE
  } map_hit_e;
endpackage

// File: rtl/i2c_bus_sync.sv
`timescale 1ns/1ps
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_s, scl_q, sda_q;

  assign scl_s = scl_pipe_q[SYNC_STAGES-1];
  assign sda_s = sda_pipe_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
      scl_q      <= 1'b1;
      sda_q      <= 1'b1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[SYNC_STAGES-2:0], scl_i};
      sda_pipe_q <= {sda_pipe_q[SYNC_STAGES-2:0], sda_i};
      scl_q      <= scl_s;
      sda_q      <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_tgt_ctrl.sv
`timescale 1ns/1ps
module i2c_tgt_ctrl
  import i2c_pg_pkg::*;
#(
  parameter logic [6:0] DEV_A = 7'h51,
  parameter logic [6:0] DEV_B = 7'h59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rdata,
  output logic              we,
  output logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] ptr,
  output logic              ch,
  output logic              sda_oe,
  output tgt_state_e        state
);
  tgt_state_e        st_q, st_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [BYTE_W-1:0] sr_q, sr_d, ptr_q, ptr_d;
  logic [BYTE_W-2:0] tx_q, tx_d;
  logic              ch_q, ch_d, rw_q, rw_d, first_q, first_d;
  logic              mack_q, mack_d, oe_q, oe_d;
  logic [BYTE_W-1:0] ptr_inc;

  // counter stays inside its 128-byte half
  assign ptr_inc = {ptr_q[BYTE_W-1], ptr_q[BYTE_W-2:0] + 7'd1};

  always_comb begin
    st_d = st_q;  cnt_d = cnt_q;  sr_d = sr_q;  tx_d = tx_q;
    ptr_d = ptr_q; ch_d = ch_q;  rw_d = rw_q;  first_d = first_q;
    mack_d = mack_q; oe_d = oe_q; we = 1'b0;
    if (stop_evt) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else if (start_evt) begin
      st_d    = ST_ADDR;
      cnt_d   = 4'd0;
      oe_d    = 1'b0;
      first_d = 1'b1;
    end else begin
      case (st_q)
        ST_ADDR, ST_WR: begin
          if (scl_rise) begin
            sr_d  = {sr_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            if (st_q == ST_ADDR) begin
              if (sr_q[7:1] == DEV_A || sr_q[7:1] == DEV_B) begin
                ch_d = (sr_q[7:1] == DEV_B);
                rw_d = sr_q[0];
                oe_d = 1'b1;
                st_d = ST_AACK;
              end else begin
                st_d = ST_IDLE;
              end
            end else begin
              oe_d = 1'b1;
              st_d = ST_WACK;
              if (first_q) begin
                ptr_d   = sr_q;
                first_d = 1'b0;
              end else begin
                we    = 1'b1;
                ptr_d = ptr_inc;
              end
            end
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt_d = 4'd0;
            if (rw_q) begin
              tx_d  = rdata[BYTE_W-2:0];
              oe_d  = ~rdata[BYTE_W-1];
              ptr_d = ptr_inc;
              st_d  = ST_RD;
            end else begin
              oe_d = 1'b0;
              st_d = ST_WR;
            end
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            oe_d  = 1'b0;
            cnt_d = 4'd0;
            st_d  = ST_WR;
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt_q == 4'd7) begin
              oe_d = 1'b0;
              st_d = ST_RACK;
            end else begin
              oe_d  = ~tx_q[BYTE_W-2];
              tx_d  = {tx_q[BYTE_W-3:0], 1'b1};
              cnt_d = cnt_q + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              tx_d  = rdata[BYTE_W-2:0];
              oe_d  = ~rdata[BYTE_W-1];
              ptr_d = ptr_inc;
              cnt_d = 4'd0;
              st_d  = ST_RD;
            end else begin
              st_d = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  cnt_q <= '0;  sr_q <= '0;  tx_q <= '0;
      ptr_q <= '0;  ch_q <= 1'b0;  rw_q <= 1'b0;  first_q <= 1'b0;
      mack_q <= 1'b0;  oe_q <= 1'b0;
    end else begin
      st_q <= st_d;  cnt_q <= cnt_d;  sr_q <= sr_d;  tx_q <= tx_d;
      ptr_q <= ptr_d;  ch_q <= ch_d;  rw_q <= rw_d;  first_q <= first_d;
      mack_q <= mack_d;  oe_q <= oe_d;
    end
  end

  assign wdata  = sr_q;
  assign ptr    = ptr_q;
  assign ch     = ch_q;
  assign sda_oe = oe_q;
  assign state  = st_q;
endmodule

// File: rtl/paged_map.sv
`timescale 1ns/1ps
module paged_map
  import i2c_pg_pkg::*;
#(
  parameter logic [7:0] MASK_OFS  = 8'h88,
  parameter int         MASK_BIT  = 0,
  parameter logic [7:0] TSEL_OFS  = 8'h7F,
  parameter logic [7:0] ENA_FIRST = 8'hF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch,
  input  logic [BYTE_W-1:0] addr,
  input  logic              we,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);
  localparam int NCH = 2;

  logic [BYTE_W-1:0] low_q [NCH][REGION];
  logic [BYTE_W-1:0] t01_q [NCH][REGION];
  logic [BYTE_W-1:0] t02_q [REGION];
  logic [REG_AW-1:0] idx;
  logic [BYTE_W-1:0] tsel;
  logic              mask;
  map_hit_e          hit;

  assign idx  = addr[REG_AW-1:0];
  assign tsel = low_q[ch][TSEL_OFS[REG_AW-1:0]];
  assign mask = t02_q[MASK_OFS[REG_AW-1:0]][MASK_BIT];

  always_comb begin
    if (!addr[BYTE_W-1]) begin
      hit = HIT_LOW;
    end else begin
      case (tsel)
        8'h01:   hit = mask ? HIT_NONE : HIT_T01;
        8'h02:   hit = HIT_T02;
        8'h05:   hit = (mask && addr >= ENA_FIRST) ? HIT_T01 : HIT_NONE;
        default: hit = HIT_NONE;
      endcase
    end
  end

  always_comb begin
    case (hit)
      HIT_LOW: rdata = low_q[ch][idx];
      HIT_T01: rdata = t01_q[ch][idx];
      HIT_T02: rdata = t02_q[idx];
      default: rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        for (int i = 0; i < REGION; i++) begin
          low_q[c][i] <= '0;
          t01_q[c][i] <= '0;
        end
      end
      for (int i = 0; i < REGION; i++) t02_q[i] <= '0;
    end else if (we) begin
      case (hit)
        HIT_LOW: low_q[ch][idx] <= wdata;
        HIT_T01: t01_q[ch][idx] <= wdata;
        HIT_T02: t02_q[idx]     <= wdata;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_paged_slave.sv
`timescale 1ns/1ps
module i2c_paged_slave
  import i2c_pg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_A  = 7'h51,
  parameter logic [6:0] DEV_ADDR_B  = 7'h59,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  logic [1:0]        rst_pipe_q;
  logic              rst_sync_n;
  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              we, ch;
  logic [BYTE_W-1:0] wdata, ptr, rdata;
  tgt_state_e        state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_tgt_ctrl #(.DEV_A(DEV_ADDR_A), .DEV_B(DEV_ADDR_B)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_evt(start_evt), .stop_evt(stop_evt),
    .rdata(rdata), .we(we), .wdata(wdata), .ptr(ptr), .ch(ch),
    .sda_oe(sda_oe), .state(state)
  );

  paged_map u_map (
    .clk(clk), .rst_n(rst_sync_n), .ch(ch), .addr(ptr), .we(we),
    .wdata(wdata), .rdata(rdata)
  );
endmodule

// File: rtl/i2c_paged_chk.sv
`timescale 1ns/1ps
module i2c_paged_chk
  import i2c_pg_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input tgt_state_e state,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       scl_fall,
  input logic       we,
  input logic [7:0] ptr
);
  assert_idle_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  assert_start_to_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !stop_evt) |=> (state == ST_ADDR));

  assert_stop_to_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (state == ST_IDLE && !sda_oe));

  assert_ptr_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (ptr[7] == $past(ptr[7]) && ptr[6:0] == $past(ptr[6:0]) + 7'd1));

  assert_sda_after_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_evt || stop_evt));
endmodule

bind i2c_paged_slave i2c_paged_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .sda_oe(sda_oe), .state(state),
  .start_evt(start_evt), .stop_evt(stop_evt), .scl_fall(scl_fall),
  .we(we), .ptr(ptr)
);

// File: tb/tb_i2c_paged_slave.sv
`timescale 1ns/1ps
module tb_i2c_paged_slave;
  localparam int Q = 8;
  localparam logic [6:0] DEV0 = 7'h51, DEV1 = 7'h59;

  logic clk, rst_n, scl, sda_m;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;
  int   nchk = 0, nerr = 0;
  logic [7:0] q [3];
  logic watch_oe, seen_oe;

  i2c_paged_slave dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (watch_oe && sda_oe) seen_oe <= 1'b1;

  // {ch, tsel, addr, wdata, expected}
  localparam logic [32:0] VECS [8] = '{
    {1'b0, 8'h00, 8'h10, 8'h3C, 8'h3C},
    {1'b1, 8'h00, 8'h10, 8'hC3, 8'hC3},
    {1'b0, 8'h02, 8'h90, 8'h5A, 8'h5A},
    {1'b0, 8'h01, 8'h85, 8'h11, 8'h11},
    {1'b1, 8'h01, 8'h85, 8'h22, 8'h22},
    {1'b0, 8'h03, 8'hA0, 8'h77, 8'hFF},
    {1'b1, 8'h05, 8'hF8, 8'h66, 8'hFF},
    {1'b1, 8'h02, 8'hA5, 8'h33, 8'h33}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic qw; repeat (Q) @(negedge clk); endtask

  task automatic bit_out(input logic b);
    sda_m = b; qw; scl = 1'b1; qw; qw; scl = 1'b0; qw;
  endtask

  task automatic bit_in(output logic b);
    sda_m = 1'b1; qw; scl = 1'b1; qw; b = sda_line; qw; scl = 1'b0; qw;
  endtask

  task automatic byte_out(input logic [7:0] d, output logic ack);
    logic nb;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(nb);
    ack = ~nb;
  endtask

  task automatic byte_in(output logic [7:0] d, input logic ack_m);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~ack_m);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; qw; scl = 1'b1; qw; sda_m = 1'b0; qw; scl = 1'b0; qw;
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; qw; scl = 1'b1; qw; sda_m = 1'b1; qw;
  endtask

  function automatic logic [7:0] dev(input logic ch, input logic rd);
    return {ch ? DEV1 : DEV0, rd};
  endfunction

  task automatic wr_seq(input logic ch, input logic [7:0] a, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic ack;
    logic [7:0] d [3];
    d = '{d0, d1, d2};
    bus_start;
    byte_out(dev(ch, 1'b0), ack); chk("R1 device ack", {7'd0, ack}, 8'h01);
    byte_out(a, ack);             chk("R6 address ack", {7'd0, ack}, 8'h01);
    for (int i = 0; i < n; i++) begin
      byte_out(d[i], ack);        chk("R6 data ack", {7'd0, ack}, 8'h01);
    end
    bus_stop;
  endtask

  task automatic rd_rand(input logic ch, input logic [7:0] a, input int n);
    logic ack;
    bus_start;
    byte_out(dev(ch, 1'b0), ack);
    byte_out(a, ack);
    bus_start;
    byte_out(dev(ch, 1'b1), ack); chk("R7 read device ack", {7'd0, ack}, 8'h01);
    for (int i = 0; i < n; i++) byte_in(q[i], i != n - 1);
    chk("R9 released after master NACK", {7'd0, sda_oe}, 8'h00);
    bus_stop;
  endtask

  task automatic rd_cur(input logic ch);
    logic ack;
    bus_start;
    byte_out(dev(ch, 1'b1), ack);
    byte_in(q[0], 1'b0);
    bus_stop;
  endtask

  task automatic set_tsel(input logic ch, input logic [7:0] t);
    wr_seq(ch, 8'h7F, 1, t, 8'h00, 8'h00);
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run;
  end

  initial begin
    logic ack;
    scl = 1'b1; sda_m = 1'b1; rst_n = 1'b0; watch_oe = 1'b0; seen_oe = 1'b0;
    repeat (10) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    // reset state
    chk("R10 reset release", {7'd0, sda_oe}, 8'h00);
    rd_rand(1'b0, 8'h10, 1); chk("R2 reset lower", q[0], 8'h00);
    rd_rand(1'b0, 8'h80, 1); chk("R3 reset table 00h reads FF", q[0], 8'hFF);

    // vector walk: select table, write one byte, random read back
    foreach (VECS[k]) begin
      set_tsel(VECS[k][32], VECS[k][31:24]);
      wr_seq(VECS[k][32], VECS[k][23:16], 1, VECS[k][15:8], 8'h00, 8'h00);
      rd_rand(VECS[k][32], VECS[k][23:16], 1);
      chk("R3 vector readback", q[0], VECS[k][7:0]);
    end

    // per-device lower regions
    rd_rand(1'b0, 8'h10, 1); chk("R2 lower separate", q[0], 8'h3C);

    // shared table through both addresses
    set_tsel(1'b1, 8'h02);
    rd_rand(1'b1, 8'h90, 1); chk("R4 shared via B", q[0], 8'h5A);
    set_tsel(1'b0, 8'h02);
    rd_rand(1'b0, 8'hA5, 1); chk("R4 shared via A", q[0], 8'h33);
    rd_rand(1'b0, 8'hA0, 1); chk("R3 unimplemented write ignored", q[0], 8'h00);
    set_tsel(1'b0, 8'h01);
    rd_rand(1'b0, 8'h85, 1); chk("R3 table 01h per device", q[0], 8'h11);

    // sequential write across FFh, sequential read
    set_tsel(1'b0, 8'h02);
    wr_seq(1'b0, 8'hFE, 3, 8'hD0, 8'hD1, 8'hD2);
    rd_rand(1'b0, 8'hFE, 3);
    chk("R6 seq byte0", q[0], 8'hD0);
    chk("R6 seq byte1", q[1], 8'hD1);
    chk("R8 upper wrap to 80h", q[2], 8'hD2);
    rd_rand(1'b0, 8'h80, 1); chk("R8 wrapped write at 80h", q[0], 8'hD2);

    // current-address read
    rd_rand(1'b0, 8'hFE, 1); chk("R7 random read", q[0], 8'hD0);
    rd_cur(1'b0);            chk("R7 current address read", q[0], 8'hD1);

    // lower half wrap: 7Fh then 00h
    rd_rand(1'b0, 8'h7F, 2);
    chk("R3 table select readback", q[0], 8'h02);
    chk("R8 lower wrap to 00h", q[1], 8'h00);

    // foreign device address
    seen_oe = 1'b0; watch_oe = 1'b1;
    bus_start;
    byte_out({7'h50, 1'b0}, ack); chk("R1 foreign address NACK", {7'd0, ack}, 8'h00);
    byte_out(8'h10, ack);
    byte_out(8'hEE, ack);         chk("R1 no ack after foreign address", {7'd0, ack}, 8'h00);
    bus_stop;
    watch_oe = 1'b0;
    chk("R1 SDA never driven", {7'd0, seen_oe}, 8'h00);
    set_tsel(1'b0, 8'h00);
    rd_rand(1'b0, 8'h10, 1); chk("R1 foreign write ignored", q[0], 8'h3C);

    // mask bit moves enable bytes into table 05h
    set_tsel(1'b1, 8'h01);
    wr_seq(1'b1, 8'hF8, 1, 8'h9E, 8'h00, 8'h00);
    set_tsel(1'b0, 8'h02);
    wr_seq(1'b0, 8'h88, 1, 8'h01, 8'h00, 8'h00);
    rd_rand(1'b1, 8'h85, 1); chk("R5 masked table 01h reads FF", q[0], 8'hFF);
    wr_seq(1'b1, 8'h85, 1, 8'hEE, 8'h00, 8'h00);
    set_tsel(1'b1, 8'h05);
    rd_rand(1'b1, 8'hF8, 1); chk("R5 enable byte in table 05h", q[0], 8'h9E);
    wr_seq(1'b1, 8'hF9, 1, 8'h4B, 8'h00, 8'h00);
    rd_rand(1'b1, 8'hF0, 1); chk("R5 table 05h below F8h reads FF", q[0], 8'hFF);
    wr_seq(1'b0, 8'h88, 1, 8'h00, 8'h00, 8'h00);
    rd_rand(1'b1, 8'hF8, 1); chk("R5 unmasked table 05h reads FF", q[0], 8'hFF);
    set_tsel(1'b1, 8'h01);
    rd_rand(1'b1, 8'hF9, 1); chk("R5 write via table 05h landed", q[0], 8'h4B);
    rd_rand(1'b1, 8'h85, 1); chk("R5 masked write ignored", q[0], 8'h22);

    chk("R10 idle release at end", {7'd0, sda_oe}, 8'h00);
    finish_run;
  end
endmodule